// File: doc/BRIEF.md
# Multiplexed Bus Exchanger

This block joins a narrow A port to a wide B port made of two equal halves: a low half and a high half. In the A-to-B direction, each B half has its own edge-triggered register. On a rising clock edge, a register loads the A word only while its own active-low clock enable is low. Two A words that arrive one after the other can therefore be collected and shown together as a single double-width B word.

In the B-to-A direction, each B half passes through its own level-sensitive latch. A latch is transparent while its active-low latch enable is low and holds its value while the enable is high. An active-low select line routes one of the two latched halves onto the A port with no clock involved. Each port is modelled as a data bus plus a one-bit drive flag. The drive flag is high when the port's active-low output enable is low, and low (bus released, high impedance) otherwise. The output enables never alter any stored value.

Top module: `bus_exchanger`

## Requirements
- R1: While reset is asserted (rst_n low), both B register halves and both B-to-A latches clear to zero, so b_out and a_out read zero.
- R2: On a rising clk edge with cke_lo_n low, b_out[11:0] takes the value of a_in.
- R3: On a rising clk edge with cke_hi_n low, b_out[23:12] takes the value of a_in.
- R4: A B register half whose clock enable is high keeps its value across clock edges.
- R5: Two A words loaded on successive edges, the first into the low half and the second into the high half, appear together on b_out as {second, first}.
- R6: The low-half latch passes b_in[11:0] while le_lo_n is low and holds its last value while le_lo_n is high, without any clock edge.
- R7: The high-half latch passes b_in[23:12] while le_hi_n is low and holds its last value while le_hi_n is high, without any clock edge.
- R8: a_out shows the low-half latch when sel_n is low and the high-half latch when sel_n is high, and it follows sel_n combinationally.
- R9: a_drive is the inverse of oea_n and b_drive is the inverse of oeb_n. Toggling either enable leaves a_out and b_out unchanged. Whenever a drive flag is high, its data bus holds no unknown bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the A-to-B registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 12 | Word arriving on the A port |
| cke_lo_n | input | 1 | Active-low load enable, low B half register |
| cke_hi_n | input | 1 | Active-low load enable, high B half register |
| b_in | input | 24 | Word arriving on the B port |
| le_lo_n | input | 1 | Active-low transparency enable, low-half latch |
| le_hi_n | input | 1 | Active-low transparency enable, high-half latch |
| sel_n | input | 1 | Half select for A: low picks low half, high picks high half |
| oea_n | input | 1 | Active-low output enable, A port |
| oeb_n | input | 1 | Active-low output enable, B port |
| a_out | output | 12 | Data presented on the A port |
| a_drive | output | 1 | High when the A port drives its data |
| b_out | output | 24 | Data presented on the B port |
| b_drive | output | 1 | High when the B port drives its data |

## Verification
The bench builds the block with its default half width of 12 bits, so the B word is 24 bits wide. At this width every enable combination and every half-packing order can be written as a hand-checked hex value. The clocked table walks every pairing of the two clock enables, including both enables low together and both high together. The directed tests then open and close each latch at times when no clock edge falls, so the checks of the asynchronous B-to-A path cannot be satisfied by a clocked implementation.

// File: rtl/bx_pkg.sv
package bx_pkg;

    // Default width of one half of the wide port.
    localparam int unsigned HALF_W_DEF = 12;

    // Which half of the wide side feeds the narrow port.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_t;

endpackage

// File: rtl/bx_cap_reg.sv
// One A-to-B capture register: loads on the rising edge while enabled.
module bx_cap_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!en_n) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bx_pass_latch.sv
// One B-to-A level-sensitive latch: transparent while le_n is low.
module bx_pass_latch #(
    parameter int unsigned W = 12
) (
    input  logic         rst_n,
    input  logic         le_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_latch begin
        if (!rst_n) begin
            q = '0;
        end else if (!le_n) begin
            q = d;
        end
    end

endmodule

// File: rtl/bx_half_mux.sv
// Chooses which latched half drives the narrow port.
module bx_half_mux
    import bx_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  half_sel_t    sel,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (sel)
            HALF_LO: y = lo;
            HALF_HI: y = hi;
            default: y = lo;
        endcase
    end

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
    import bx_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HALF_W-1:0]     a_in,
    input  logic                  cke_lo_n,
    input  logic                  cke_hi_n,
    input  logic [2*HALF_W-1:0]   b_in,
    input  logic                  le_lo_n,
    input  logic                  le_hi_n,
    input  logic                  sel_n,
    input  logic                  oea_n,
    input  logic                  oeb_n,
    output logic [HALF_W-1:0]     a_out,
    output logic                  a_drive,
    output logic [2*HALF_W-1:0]   b_out,
    output logic                  b_drive
);

    localparam int unsigned N_HALF = 2;
    localparam int unsigned WIDE_W = N_HALF * HALF_W;

    logic [N_HALF-1:0]      cke_n;
    logic [N_HALF-1:0]      le_n;
    logic [HALF_W-1:0]      reg_q   [N_HALF];
    logic [HALF_W-1:0]      latch_q [N_HALF];
    logic [WIDE_W-1:0]      wide_q;
    half_sel_t              half_sel;

    assign cke_n = {cke_hi_n, cke_lo_n};
    assign le_n  = {le_hi_n,  le_lo_n};

    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        bx_cap_reg #(.W(HALF_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .en_n  (cke_n[g]),
            .d     (a_in),
            .q     (reg_q[g])
        );

        bx_pass_latch #(.W(HALF_W)) u_latch (
            .rst_n (rst_n),
            .le_n  (le_n[g]),
            .d     (b_in[g*HALF_W +: HALF_W]),
            .q     (latch_q[g])
        );

        assign wide_q[g*HALF_W +: HALF_W] = reg_q[g];
    end

    assign half_sel = sel_n ? HALF_HI : HALF_LO;

    bx_half_mux #(.W(HALF_W)) u_mux (
        .sel (half_sel),
        .lo  (latch_q[0]),
        .hi  (latch_q[1]),
        .y   (a_out)
    );

    assign b_out   = wide_q;
    assign a_drive = ~oea_n;
    assign b_drive = ~oeb_n;

endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
    parameter int unsigned HALF_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [HALF_W-1:0]   a_in,
    input logic                cke_lo_n,
    input logic                cke_hi_n,
    input logic [2*HALF_W-1:0] b_in,
    input logic                le_lo_n,
    input logic                le_hi_n,
    input logic                sel_n,
    input logic [HALF_W-1:0]   a_out,
    input logic                a_drive,
    input logic [2*HALF_W-1:0] b_out,
    input logic                b_drive
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (b_out == '0 && a_out == '0));  // R1

    AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_lo_n |=> b_out[HALF_W-1:0] == $past(a_in));  // R2

    AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_hi_n |=> b_out[2*HALF_W-1:HALF_W] == $past(a_in));  // R3

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke_lo_n |=> $stable(b_out[HALF_W-1:0]));  // R4

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke_hi_n |=> $stable(b_out[2*HALF_W-1:HALF_W]));  // R4

    AST_LO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_lo_n && !sel_n) |-> a_out == b_in[HALF_W-1:0]);  // R6

    AST_HI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_hi_n && sel_n) |-> a_out == b_in[2*HALF_W-1:HALF_W]);  // R7

    AST_A_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        a_drive |-> !$isunknown(a_out));  // R9

    AST_B_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        b_drive |-> !$isunknown(b_out));  // R9

endmodule

bind bus_exchanger bus_exchanger_chk #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_in     (a_in),
    .cke_lo_n (cke_lo_n),
    .cke_hi_n (cke_hi_n),
    .b_in     (b_in),
    .le_lo_n  (le_lo_n),
    .le_hi_n  (le_hi_n),
    .sel_n    (sel_n),
    .a_out    (a_out),
    .a_drive  (a_drive),
    .b_out    (b_out),
    .b_drive  (b_drive)
);

// File: tb/bus_exchanger_test.sv
module bus_exchanger_test;

    localparam int CLK_PERIOD = 10;
    localparam int HW = 12;
    localparam int NVEC = 6;

    // {cke_lo_n, cke_hi_n, a_in[11:0], expected b_out[23:0]}
    localparam logic [37:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 12'hABC, 24'h000ABC},  // R2
        {1'b1, 1'b0, 12'h123, 24'h123ABC},  // R3, R5
        {1'b1, 1'b1, 12'hFFF, 24'h123ABC},  // R4
        {1'b0, 1'b0, 12'h5A5, 24'h5A55A5},  // R2, R3
        {1'b1, 1'b0, 12'h00F, 24'h00F5A5},  // R3, R4
        {1'b0, 1'b1, 12'hF00, 24'h00FF00}   // R2, R4
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [HW-1:0]   a_in = '0;
    logic            cke_lo_n = 1'b1;
    logic            cke_hi_n = 1'b1;
    logic [2*HW-1:0] b_in = '0;
    logic            le_lo_n = 1'b1;
    logic            le_hi_n = 1'b1;
    logic            sel_n = 1'b0;
    logic            oea_n = 1'b1;
    logic            oeb_n = 1'b1;
    logic [HW-1:0]   a_out;
    logic            a_drive;
    logic [2*HW-1:0] b_out;
    logic            b_drive;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_exchanger #(.HALF_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in),
        .cke_lo_n(cke_lo_n), .cke_hi_n(cke_hi_n), .b_in(b_in),
        .le_lo_n(le_lo_n), .le_hi_n(le_hi_n), .sel_n(sel_n),
        .oea_n(oea_n), .oeb_n(oeb_n),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 b_out", b_out, 24'h0);
        chk("R1 a_out", {12'h0, a_out}, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Clocked A-to-B table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            cke_lo_n = VEC[i][37];
            cke_hi_n = VEC[i][36];
            a_in     = VEC[i][35:24];
            @(posedge clk);
            #1;
            chk("R2/R3/R4/R5 table", b_out, VEC[i][23:0]);
        end
        @(negedge clk);
        cke_lo_n = 1'b1;
        cke_hi_n = 1'b1;

        // B-to-A latches, driven between clock edges
        #1;
        b_in = 24'h456789; le_lo_n = 1'b0; le_hi_n = 1'b0; sel_n = 1'b0;
        #1 chk("R6 low pass", {12'h0, a_out}, 24'h000789);
        sel_n = 1'b1;
        #1 chk("R8 select high", {12'h0, a_out}, 24'h000456);
        le_lo_n = 1'b1; le_hi_n = 1'b1;
        #1 b_in = 24'hFFF000;
        #1 chk("R7 high hold", {12'h0, a_out}, 24'h000456);
        sel_n = 1'b0;
        #1 chk("R6 low hold", {12'h0, a_out}, 24'h000789);
        le_hi_n = 1'b0;
        #1 chk("R6 low hold, high open", {12'h0, a_out}, 24'h000789);
        sel_n = 1'b1;
        #1 chk("R7 high pass", {12'h0, a_out}, 24'h000FFF);
        le_hi_n = 1'b1;
        #1 b_in = 24'h111222;
        #1 chk("R7 high hold again", {12'h0, a_out}, 24'h000FFF);

        // Output enables
        oea_n = 1'b0;
        #1 chk("R9 a_drive on", {23'h0, a_drive}, 24'h1);
        chk("R9 a_out kept", {12'h0, a_out}, 24'h000FFF);
        oea_n = 1'b1;
        #1 chk("R9 a_drive off", {23'h0, a_drive}, 24'h0);
        chk("R9 a_out kept off", {12'h0, a_out}, 24'h000FFF);
        oeb_n = 1'b0;
        #1 chk("R9 b_drive on", {23'h0, b_drive}, 24'h1);
        @(posedge clk);
        #1;
        oeb_n = 1'b1;
        #1 chk("R9 b_drive off", {23'h0, b_drive}, 24'h0);
        chk("R9 b_out kept", b_out, 24'h00FF00);

        // Reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 b_out re-reset", b_out, 24'h0);
        chk("R1 a_out re-reset", {12'h0, a_out}, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule